// File: doc/BRIEF.md
# Per-Channel Amplitude Serial Transmitter

This block serves one channel of a many-channel fast timing path. A peak-found strobe starts an event. The block first marks the moment of the peak on its single serial output line. It then waits a programmable number of clock cycles while an external converter settles. After that it captures a 6-bit amplitude code and ships it out most significant bit first. Bits leave on both edges of a dedicated serial clock, so the 6 bits take three clock periods. A one-period quiet phase on the line follows, and then the channel reports that it is ready for the next event.

The converter is modelled as a parallel 6-bit input that is sampled once per event. A busy output covers the whole event. A strobe that arrives while the channel is busy is dropped, and that drop sets a sticky overrun flag. With the nominal delay of 4 cycles at 160 MHz the whole event lasts 9 cycles (about 56 ns). With the largest delay of 7 it lasts 12 cycles (75 ns). Both stay inside the 100 ns dead-time budget.

Top module: `amp_serial_tx`

## Requirements
- R1: After reset, and whenever no event is in progress, `ser_o` is low in both clock halves, `busy_o` is 0, `ready_o` is 1 and `overrun_o` is 0 (the last until a strobe is dropped).
- R2: When `peak_i` is high at a rising edge while the channel is idle, `ser_o` is high for the whole clock period that follows that edge; this is the peak marker.
- R3: After the marker, `ser_o` stays low for exactly D full clock periods, where D is the value of `conv_dly_i` (0 to 7) sampled at the rising edge that ends the marker period.
- R4: The amplitude code is the value of `amp_code_i` sampled at the rising edge that ends the wait (the edge that ends the marker when D is 0). Changes to `amp_code_i` at any other time have no effect on the transmitted bits.
- R5: The code is sent over the next three clock periods. In period j (j = 0, 1, 2), the high half carries bit 5-2j and the low half carries bit 4-2j, so bit 5 goes first and bit 0 goes last.
- R6: After bit 0, `ser_o` stays low for one full clock period (the reset phase). At the rising edge that ends this period, `busy_o` falls and `ready_o` rises.
- R7: `busy_o` is high, and `ready_o` is low, from the rising edge that starts the marker until the end of the reset phase, which is D+5 clock periods in total.
- R8: A `peak_i` seen at a rising edge while `busy_o` is high does not start an event and does not change the waveform on the line. It sets `overrun_o`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated serial clock; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| peak_i | input | 1 | Peak-found strobe, sampled on rising edges |
| conv_dly_i | input | 3 | Conversion wait in clock periods (nominal 4) |
| amp_code_i | input | 6 | Parallel amplitude code from the converter |
| ser_o | output | 1 | Serial line: marker, amplitude bits, then low |
| busy_o | output | 1 | An event is in progress |
| ready_o | output | 1 | Ready to accept the next peak-found strobe |
| overrun_o | output | 1 | Sticky: a strobe was dropped while busy |

## Verification
Take E as the rising edge at which the strobe is accepted. The marker then occupies the period after E, the wait runs from E+1 through E+D, the data periods start at E+D+1, the reset phase is period E+D+4, and `busy_o` falls at edge E+D+5. The flag outputs change at rising edges, so the bench samples them and the high half of `ser_o` 2 ns after each rising edge. It samples the low half 2 ns after the falling edge. A behavioural model in the bench advances one step per rising edge and predicts both halves, so every clock period is compared. The amplitude input changes every cycle in some events, which pins the capture to the single edge that R4 names.

// File: rtl/ast_pkg.sv
package ast_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MARK = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_RST  = 3'd4
  } ast_state_e;

  // Two line values for one clock period: hi in the high half, lo in the low half.
  typedef struct packed {
    logic hi;
    logic lo;
  } ast_pair_t;
endpackage

// File: rtl/ast_ctrl.sv
module ast_ctrl
  import ast_pkg::*;
#(
  parameter int DLY_W = 3,
  parameter int NBEAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             peak_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             mark_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             overrun_o
);
  localparam int BEAT_W = (NBEAT > 1) ? $clog2(NBEAT) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NBEAT - 1);

  ast_state_e        state_q, state_n;
  logic [DLY_W-1:0]  cnt_q, cnt_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic              ovr_q, ovr_n;
  logic              cnt_en, beat_en;

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    beat_n  = beat_q;
    ovr_n   = ovr_q;
    mark_o  = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    cnt_en  = 1'b0;
    beat_en = 1'b0;
    if (peak_i && (state_q != ST_IDLE)) ovr_n = 1'b1;
    unique case (state_q)
      ST_IDLE: if (peak_i) begin
        state_n = ST_MARK;
        mark_o  = 1'b1;
      end
      ST_MARK: begin
        if (delay_i == '0) begin
          state_n = ST_DATA;
          load_o  = 1'b1;
          beat_n  = '0;
          beat_en = 1'b1;
        end else begin
          state_n = ST_WAIT;
          cnt_n   = delay_i;
          cnt_en  = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cnt_q == DLY_W'(1)) begin
          state_n = ST_DATA;
          load_o  = 1'b1;
          beat_n  = '0;
          beat_en = 1'b1;
        end else begin
          cnt_n  = cnt_q - DLY_W'(1);
          cnt_en = 1'b1;
        end
      end
      ST_DATA: begin
        if (beat_q == LAST_BEAT) begin
          state_n = ST_RST;
        end else begin
          beat_n  = beat_q + BEAT_W'(1);
          beat_en = 1'b1;
          adv_o   = 1'b1;
        end
      end
      ST_RST:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ovr_q   <= ovr_n;
      if (cnt_en)  cnt_q  <= cnt_n;
      if (beat_en) beat_q <= beat_n;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign overrun_o = ovr_q;

  // R8: a strobe while busy is dropped and flagged
  p_peak_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && peak_i) |=> overrun_o);
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  // R7: an event only begins from a sampled strobe
  p_start_from_peak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(peak_i));
  // R6: reset phase is a single period, then idle
  p_rst_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST) |=> !busy_o);
  // R3: the wait never runs past its programmed length
  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q != '0));
endmodule

// File: rtl/ast_shift.sv
module ast_shift
  import ast_pkg::*;
#(
  parameter int AMP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [AMP_W-1:0] code_i,
  output ast_pair_t        pair_o
);
  logic [AMP_W-1:0] shreg_q, shreg_n;
  logic             shreg_en;

  // next-state logic: choose the two bits for the coming period
  always_comb begin
    shreg_n  = shreg_q;
    shreg_en = 1'b0;
    pair_o   = '0;
    if (mark_i) begin
      pair_o = '{hi: 1'b1, lo: 1'b1};
    end else if (load_i) begin
      pair_o   = '{hi: code_i[AMP_W-1], lo: code_i[AMP_W-2]};
      shreg_n  = code_i << 2;
      shreg_en = 1'b1;
    end else if (adv_i) begin
      pair_o   = '{hi: shreg_q[AMP_W-1], lo: shreg_q[AMP_W-2]};
      shreg_n  = shreg_q << 2;
      shreg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '0;
    else if (shreg_en) shreg_q <= shreg_n;
  end

  // R4: capture and shift never happen together
  p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mark_i, load_i, adv_i}) <= 1);
endmodule

// File: rtl/ast_ddr_out.sv
module ast_ddr_out
  import ast_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ast_pair_t pair_i,
  output logic      ser_o
);
  logic hi_q, lo_hold_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= 1'b0;
      lo_hold_q <= 1'b0;
    end else begin
      hi_q      <= pair_i.hi;
      lo_hold_q <= pair_i.lo;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= lo_hold_q;
  end

  // Clock-selected mux: each half is driven by a register of its own edge.
  assign ser_o = clk ? hi_q : lo_q;
endmodule

// File: rtl/amp_serial_tx.sv
module amp_serial_tx
  import ast_pkg::*;
#(
  parameter int AMP_W = 6,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             peak_i,
  input  logic [DLY_W-1:0] conv_dly_i,
  input  logic [AMP_W-1:0] amp_code_i,
  output logic             ser_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             overrun_o
);
  localparam int NBEAT = AMP_W / 2;

  logic      mark_w, load_w, adv_w;
  ast_pair_t pair_w;

  ast_ctrl #(.DLY_W(DLY_W), .NBEAT(NBEAT)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .peak_i    (peak_i),
    .delay_i   (conv_dly_i),
    .mark_o    (mark_w),
    .load_o    (load_w),
    .adv_o     (adv_w),
    .busy_o    (busy_o),
    .overrun_o (overrun_o)
  );

  ast_shift #(.AMP_W(AMP_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark_i (mark_w),
    .load_i (load_w),
    .adv_i  (adv_w),
    .code_i (amp_code_i),
    .pair_o (pair_w)
  );

  ast_ddr_out i_ddr (
    .clk    (clk),
    .rst_n  (rst_n),
    .pair_i (pair_w),
    .ser_o  (ser_o)
  );

  assign ready_o = !busy_o;

  // R1: a period spent idle leaves the line low in its low half
  p_line_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ser_o);
  // R2: an accepted strobe always opens with the marker
  p_marker_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && peak_i) |=> busy_o);
endmodule

// File: tb/test_amp_serial_tx.sv
module test_amp_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       peak_i = 1'b0;
  logic [2:0] conv_dly_i = 3'd4;
  logic [5:0] amp_code_i = 6'd0;
  logic       ser_o, busy_o, ready_o, overrun_o;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 1'b0;
  bit  code_free = 1'b0;
  int  cyc_n = 0;

  // behavioural model state
  int       m_k = -1;
  int       m_d = 0;
  logic [5:0] m_code = '0;
  bit       m_ovr = 1'b0;

  always #5 clk = ~clk;

  amp_serial_tx i_amp_serial_tx (
    .clk(clk), .rst_n(rst_n), .peak_i(peak_i), .conv_dly_i(conv_dly_i),
    .amp_code_i(amp_code_i), .ser_o(ser_o), .busy_o(busy_o),
    .ready_o(ready_o), .overrun_o(overrun_o)
  );

  function automatic logic exp_bit(input bit lo_half);
    int j;
    if (m_k < 0) return 1'b0;
    if (m_k == 0) return 1'b1;
    if (m_k <= m_d) return 1'b0;
    j = m_k - m_d - 1;
    if (j < 3) return lo_half ? m_code[4 - 2*j] : m_code[5 - 2*j];
    return 1'b0;
  endfunction

  function automatic string phase_tag();
    if (m_k < 0) return "R1";
    if (m_k == 0) return "R2";
    if (m_k <= m_d) return "R3";
    if (m_k <= m_d + 3) return "R4/R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc_n, act, exp);
    end
  endtask

  // reference model step and comparison, once per clock period
  always @(posedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      m_k = -1; m_ovr = 1'b0;
    end else if (m_k < 0) begin
      if (peak_i) begin m_k = 0; m_d = 0; end
    end else begin
      if (peak_i) m_ovr = 1'b1;
      m_k++;
      if (m_k == 1) m_d = int'(conv_dly_i);
      if (m_k == m_d + 1) m_code = amp_code_i;
      if (m_k == m_d + 5) m_k = -1;
    end
    #2;
    if (rst_n && !done) begin
      check(phase_tag(), "ser high half", ser_o, exp_bit(1'b0));
      check(m_k < 0 ? "R1" : "R7", "busy", busy_o, m_k >= 0);
      check(m_k < 0 ? "R1" : "R7", "ready", ready_o, m_k < 0);
      check(m_ovr ? "R8" : "R1", "overrun", overrun_o, m_ovr);
    end
    #5;
    if (rst_n && !done) check(phase_tag(), "ser low half", ser_o, exp_bit(1'b1));
  end

  // free-running amplitude input, to prove the single capture edge (R4)
  initial forever begin
    @(posedge clk); #1;
    if (code_free) amp_code_i = 6'((cyc_n * 37 + 11) & 63);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic event_once(input logic [2:0] d, input int fixed_code);
    conv_dly_i = d;
    if (fixed_code >= 0) begin code_free = 1'b0; amp_code_i = 6'(fixed_code); end
    else code_free = 1'b1;
    peak_i = 1'b1; cyc(1); peak_i = 1'b0;
    cyc(int'(d) + 7);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);                               // R1 idle checks
    event_once(3'd4, 6'h2A);              // nominal delay, alternating bits
    event_once(3'd0, 6'h3F);              // R3 zero wait, all ones
    event_once(3'd7, -1);                 // R3 longest wait, moving input (R4)
    event_once(3'd1, 6'h00);              // all zeros
    event_once(3'd5, 6'h15);
    event_once(3'd2, -1);
    // R8: strobe held high: drops during busy, back-to-back restart
    conv_dly_i = 3'd2; code_free = 1'b1;
    peak_i = 1'b1; cyc(20); peak_i = 1'b0;
    cyc(10);
    // R8: flag stays until reset; reset in the middle of an event
    peak_i = 1'b1; cyc(1); peak_i = 1'b0; cyc(2);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
    event_once(3'd3, -1);
    event_once(3'd6, 6'h21);
    cyc(4);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc_n);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule